// File: doc/BRIEF.md
# Reset and Ready-Busy Sequencer

This block decides how the chip reacts when its external active-low reset pin is pulled. The pin first passes through a two-flop synchroniser. A low level is then timed in clock cycles, and a pulse is acted on only once it has lasted a minimum number of cycles. Shorter pulses are treated as noise and leave every output alone.

A reset pulse that is long enough does four things:

- It sends a single-cycle abort request to the command interpreter, which drops any embedded program or erase and returns to array reads.
- It tristates the data outputs.
- It makes the command logic ignore bus reads and writes.
- It starts an internal recovery interval.

The recovery interval is long if the operation engine was busy when the reset took effect, and short if it was idle. The ready output stays low for that interval and at any time the engine reports busy. After the pin returns high, outputs stay tristated and commands stay ignored for a further hold-off interval. All delays are parameters counted in clock cycles.

Top module: `rrb_reset_ready`

## Requirements
- R1: After the block's own reset `sys_rst_n` is released with the pin high and the engine idle, `ready`=1, `out_hiz`=0, `cmd_block`=0 and `abort_req`=0.
- R2: A pin low pulse of fewer than MIN_PULSE clock cycles causes no abort and leaves `out_hiz` and `cmd_block` at 0. Throughout such a pulse, `ready` keeps following the engine busy flag.
- R3: A pin low pulse of exactly MIN_PULSE cycles is honoured. `out_hiz` and `cmd_block` go to 1 at the (MIN_PULSE+3)th rising edge after the pin is first driven low, and are still 0 one edge earlier.
- R4: Each honoured pulse raises `abort_req` for exactly one cycle. That cycle is the first cycle in which `out_hiz` and `cmd_block` are 1.
- R5: `out_hiz` and `cmd_block` stay 1 while the pin is low. They stay 1 for HOLD_CYC+2 cycles after the pin returns high, and fall to 0 at edge HOLD_CYC+3 after the release.
- R6: If `engine_busy` is 1 in the cycle the pulse is honoured, `ready` is 0 for BUSY_RECOV cycles starting with the abort cycle, provided `engine_busy` has dropped. It is 1 in the cycle after that interval.
- R7: If `engine_busy` is 0 when the pulse is honoured, `ready` is 0 for IDLE_RECOV cycles starting with the abort cycle. It is 1 afterwards, even while the pin is still held low.
- R8: `ready` is 0 in every cycle in which `engine_busy` is 1.
- R9: A new valid pulse arriving during the hold-off interval is honoured again with a fresh abort. `out_hiz` does not drop in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of this block's flops |
| rst_pin_n | input | 1 | External active-low reset pin, asynchronous to `clk` |
| engine_busy | input | 1 | High while an embedded program or erase runs |
| abort_req | output | 1 | One-cycle request to abort and return to array reads |
| out_hiz | output | 1 | High: drive data outputs to high impedance |
| cmd_block | output | 1 | High: command logic ignores reads and writes |
| ready | output | 1 | Ready/busy output: 1 ready, 0 busy or recovering |

## Verification
Every response is a fixed number of cycles after the pin edge. Two synchroniser stages, MIN_PULSE width-counter cycles and one sequencer register put the honour at edge MIN_PULSE+3. Release detection takes three edges, so `out_hiz` falls at edge HOLD_CYC+3 after the pin rises. The recovery counter is loaded on the honour edge, so `ready` rises BUSY_RECOV or IDLE_RECOV cycles after the abort.

The bench drives the pin on falling clock edges and samples on later falling edges. It counts those edges in a loop and checks the output on both sides of each predicted transition, so an off-by-one in any stage shows up.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,   // normal operation
        SEQ_HELD = 2'd1,   // valid reset pulse still active
        SEQ_HOLD = 2'd2    // pin released, read hold-off running
    } seq_state_e;
endpackage

// File: rtl/rrb_sync2.sv
module rrb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1};
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/rrb_width_filter.sv
module rrb_width_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    output logic pulse_ok
);
    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (pin_sync)          cnt_d = '0;
        else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_ok = (cnt_q == CMAX);
endmodule

// File: rtl/rrb_seq_core.sv
module rrb_seq_core
    import rrb_pkg::*;
#(
    parameter int BUSY_RECOV = 40,
    parameter int IDLE_RECOV = 10,
    parameter int HOLD_CYC   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_ok,
    input  logic pin_high,
    input  logic engine_busy,
    output logic abort_req,
    output logic blocked,
    output logic recov_active
);
    localparam int RMAX = (BUSY_RECOV > IDLE_RECOV) ? BUSY_RECOV : IDLE_RECOV;
    localparam int RW   = $clog2(RMAX + 1);
    localparam int HW   = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [HW-1:0] hold;
        logic [RW-1:0] rec;
        logic          abort;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.abort = 1'b0;
        if (st_q.rec != '0) st_d.rec = st_q.rec - 1'b1;

        unique case (st_q.state)
            SEQ_RUN: begin
                if (pulse_ok) begin
                    st_d.state = SEQ_HELD;
                    st_d.abort = 1'b1;
                    st_d.rec   = engine_busy ? RW'(BUSY_RECOV) : RW'(IDLE_RECOV);
                end
            end
            SEQ_HELD: begin
                if (pin_high) begin
                    st_d.state = SEQ_HOLD;
                    st_d.hold  = HW'(HOLD_CYC);
                end
            end
            SEQ_HOLD: begin
                if (pulse_ok) begin
                    st_d.state = SEQ_HELD;
                    st_d.abort = 1'b1;
                    st_d.rec   = engine_busy ? RW'(BUSY_RECOV) : RW'(IDLE_RECOV);
                end else if (st_q.hold <= HW'(1)) begin
                    st_d.state = SEQ_RUN;
                    st_d.hold  = '0;
                end else begin
                    st_d.hold = st_q.hold - 1'b1;
                end
            end
            default: st_d.state = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SEQ_RUN, hold: '0, rec: '0, abort: 1'b0};
        else        st_q <= st_d;
    end

    assign abort_req    = st_q.abort;
    assign blocked      = (st_q.state != SEQ_RUN);
    assign recov_active = (st_q.rec != '0);
endmodule

// File: rtl/rrb_reset_ready.sv
module rrb_reset_ready #(
    parameter int MIN_PULSE  = 4,
    parameter int BUSY_RECOV = 40,
    parameter int IDLE_RECOV = 10,
    parameter int HOLD_CYC   = 8
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic rst_pin_n,
    input  logic engine_busy,
    output logic abort_req,
    output logic out_hiz,
    output logic cmd_block,
    output logic ready
);
    logic pin_s;
    logic pulse_ok;
    logic blocked;
    logic recov_active;

    rrb_sync2 u_sync (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .async_in (rst_pin_n),
        .sync_out (pin_s)
    );

    rrb_width_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .pin_sync (pin_s),
        .pulse_ok (pulse_ok)
    );

    rrb_seq_core #(
        .BUSY_RECOV (BUSY_RECOV),
        .IDLE_RECOV (IDLE_RECOV),
        .HOLD_CYC   (HOLD_CYC)
    ) u_core (
        .clk          (clk),
        .rst_n        (sys_rst_n),
        .pulse_ok     (pulse_ok),
        .pin_high     (pin_s),
        .engine_busy  (engine_busy),
        .abort_req    (abort_req),
        .blocked      (blocked),
        .recov_active (recov_active)
    );

    assign out_hiz   = blocked;
    assign cmd_block = blocked;
    assign ready     = ~(engine_busy | recov_active);
endmodule

// File: rtl/rrb_reset_ready_chk.sv
module rrb_reset_ready_chk (
    input logic clk,
    input logic sys_rst_n,
    input logic rst_pin_n,
    input logic engine_busy,
    input logic abort_req,
    input logic out_hiz,
    input logic cmd_block,
    input logic ready
);
    // R4: the abort request lasts a single cycle
    a_r4_abort_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
        abort_req |=> !abort_req);

    // R4: abort coincides with tristate and command blocking
    a_r4_abort_blocks: assert property (@(posedge clk) disable iff (!sys_rst_n)
        abort_req |-> (out_hiz && cmd_block));

    // R3: tristating only ever starts together with an abort
    a_r3_hiz_starts_with_abort: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(out_hiz) |-> abort_req);

    // R2: an abort needs the pin to have been low, counted through the pipeline
    a_r2_abort_needs_low_pin: assert property (@(posedge clk) disable iff (!sys_rst_n)
        abort_req |-> !$past(rst_pin_n, 4));

    // R8: busy engine always means not ready
    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!sys_rst_n)
        engine_busy |-> !ready);
endmodule

bind rrb_reset_ready rrb_reset_ready_chk u_chk (
    .clk         (clk),
    .sys_rst_n   (sys_rst_n),
    .rst_pin_n   (rst_pin_n),
    .engine_busy (engine_busy),
    .abort_req   (abort_req),
    .out_hiz     (out_hiz),
    .cmd_block   (cmd_block),
    .ready       (ready)
);

// File: tb/sim_rrb_reset_ready.sv
module sim_rrb_reset_ready;
    localparam int CLK_PERIOD = 10;
    localparam int MP = 4;
    localparam int BR = 40;
    localparam int IR = 10;
    localparam int HC = 8;

    logic clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic rst_pin_n = 1'b1;
    logic engine_busy = 1'b0;
    logic abort_req, out_hiz, cmd_block, ready;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rrb_reset_ready #(
        .MIN_PULSE(MP), .BUSY_RECOV(BR), .IDLE_RECOV(IR), .HOLD_CYC(HC)
    ) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .rst_pin_n(rst_pin_n),
        .engine_busy(engine_busy), .abort_req(abort_req), .out_hiz(out_hiz),
        .cmd_block(cmd_block), .ready(ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) tick();
        sys_rst_n = 1'b1;
        repeat (2) tick();
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(out_hiz == 1'b0, "R1 out_hiz", int'(out_hiz), 0);
        chk(cmd_block == 1'b0, "R1 cmd_block", int'(cmd_block), 0);
        chk(abort_req == 1'b0, "R1 abort", int'(abort_req), 0);
    endtask

    // R2: pulse one cycle short of the minimum
    task automatic t_short_pulse();
        int aborts = 0;
        int hiz = 0;
        int rdy = 0;
        engine_busy = 1'b1;
        rst_pin_n = 1'b0;
        repeat (MP-1) tick();
        rst_pin_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            tick();
            aborts += int'(abort_req);
            hiz += int'(out_hiz | cmd_block);
            rdy += int'(ready);
        end
        chk(aborts == 0, "R2 no abort", aborts, 0);
        chk(hiz == 0, "R2 no blocking", hiz, 0);
        chk(rdy == 0, "R2 ready follows busy", rdy, 0);
        engine_busy = 1'b0;
        tick();
        chk(ready == 1'b1, "R2 ready after busy drop", int'(ready), 1);
    endtask

    // R3: pulse of exactly the minimum width is honoured
    task automatic t_min_width();
        int aborts = 0;
        rst_pin_n = 1'b0;
        repeat (MP) tick();
        rst_pin_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            tick();
            aborts += int'(abort_req);
        end
        chk(aborts == 1, "R3 minimum pulse honoured", aborts, 1);
        repeat (IR + HC + 6) tick();
        chk(out_hiz == 1'b0, "R3 back to run", int'(out_hiz), 0);
    endtask

    // R3 R4 R5 R7: idle reset, timing of every output
    task automatic t_idle_reset();
        rst_pin_n = 1'b0;
        for (int k = 1; k <= MP+2; k++) tick();
        chk(out_hiz == 1'b0, "R3 not yet blocked", int'(out_hiz), 0);
        chk(ready == 1'b1, "R7 ready before honour", int'(ready), 1);
        tick();
        chk(out_hiz == 1'b1 && cmd_block == 1'b1, "R3 blocked at edge MP+3",
            int'(out_hiz & cmd_block), 1);
        chk(abort_req == 1'b1, "R4 abort raised", int'(abort_req), 1);
        chk(ready == 1'b0, "R7 recovering", int'(ready), 0);
        tick();
        chk(abort_req == 1'b0, "R4 abort one cycle", int'(abort_req), 0);
        for (int k = MP+5; k <= MP+2+IR; k++) tick();
        chk(ready == 1'b0, "R7 last recovery cycle", int'(ready), 0);
        tick();
        chk(ready == 1'b1, "R7 ready after short recovery", int'(ready), 1);
        chk(out_hiz == 1'b1, "R5 blocked while pin low", int'(out_hiz), 1);
        rst_pin_n = 1'b1;
        for (int k = 1; k <= HC+2; k++) tick();
        chk(out_hiz == 1'b1 && cmd_block == 1'b1, "R5 hold-off last cycle",
            int'(out_hiz & cmd_block), 1);
        tick();
        chk(out_hiz == 1'b0 && cmd_block == 1'b0, "R5 released",
            int'(out_hiz | cmd_block), 0);
    endtask

    // R6 R8: reset during a running operation
    task automatic t_busy_reset();
        engine_busy = 1'b1;
        tick();
        chk(ready == 1'b0, "R8 busy not ready", int'(ready), 0);
        rst_pin_n = 1'b0;
        for (int k = 1; k <= MP+3; k++) tick();
        chk(abort_req == 1'b1, "R6 abort during busy", int'(abort_req), 1);
        engine_busy = 1'b0;
        for (int k = MP+4; k <= MP+2+BR; k++) tick();
        chk(ready == 1'b0, "R6 long recovery last cycle", int'(ready), 0);
        tick();
        chk(ready == 1'b1, "R6 ready after long recovery", int'(ready), 1);
        rst_pin_n = 1'b1;
        repeat (HC + 4) tick();
        chk(out_hiz == 1'b0, "R6 released", int'(out_hiz), 0);
    endtask

    // R9: new valid pulse during hold-off
    task automatic t_reassert();
        int aborts = 0;
        int lows = 0;
        rst_pin_n = 1'b0;
        repeat (MP + 4) tick();
        rst_pin_n = 1'b1;
        tick();
        rst_pin_n = 1'b0;
        for (int k = 0; k < 14; k++) begin
            tick();
            aborts += int'(abort_req);
            lows += int'(!out_hiz);
        end
        chk(aborts == 1, "R9 fresh abort", aborts, 1);
        chk(lows == 0, "R9 no gap in blocking", lows, 0);
        rst_pin_n = 1'b1;
        repeat (HC + IR + 6) tick();
        chk(out_hiz == 1'b0 && ready == 1'b1, "R9 recovered",
            int'(out_hiz | ~ready), 0);
    endtask

    initial begin
        t_reset();
        t_short_pulse();
        t_min_width();
        t_idle_reset();
        t_busy_reset();
        t_reassert();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule